// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block performs one step of an 8-bit accumulator datapath. The surrounding control logic presents the current accumulator byte, a second operand byte, the current five status flags and an operation code. When the execute strobe is high at a rising clock edge, the block stores the new accumulator value and the new flag set. Both stay on the outputs until the next strobe. The caller routes the outputs back as the next step's inputs, or loads fresh values. The block does not fetch operands from registers or memory.

The operations are:
- binary add and subtract, each with or without the incoming carry;
- compare;
- the three bitwise logic functions;
- four single-bit rotates, two circular and two through the carry;
- accumulator complement, carry complement and carry set;
- accumulator increment and decrement;
- BCD decimal adjust.

Each operation updates only the flags that belong to it. For example, the rotates alter only the carry. Compare updates the flags but writes back the old accumulator. AND always raises the half-carry.

Top module: `acc_alu8`

## Requirements
- R1: After an asynchronous active-low reset, acc_o and flags_o are both zero. In any cycle where exec_i is low at the rising edge, acc_o and flags_o keep their values.
- R2: Flag bus positions are bit 0 carry, bit 1 parity, bit 2 half-carry, bit 3 zero, bit 4 sign. The arithmetic codes are:
  - op 0 adds the operand and op 1 also adds the incoming carry. Carry is set on a carry out of bit 7 and half-carry on a carry out of bit 3.
  - op 2 subtracts the operand and op 3 also subtracts the incoming carry. Carry is set on a borrow out of bit 7 and half-carry on a borrow out of bit 3.
- R3: Compare (op 4) sets the flags exactly as op 2 would, but acc_o takes the unchanged accumulator. Carry=1 means acc<operand; zero=1 means equal.
- R4: AND (op 5) stores acc&operand, updates sign, zero and parity, clears carry and sets half-carry.
- R5: OR (op 6) and XOR (op 7) store their results, update sign, zero and parity, and clear both carry and half-carry.
- R6: Op 8 rotates left, copying bit 7 into bit 0 and carry (A8h gives 51h, carry 1). Op 9 rotates right, copying bit 0 into bit 7 and carry (A8h gives 54h, carry 0).
- R7: Op 10 shifts left with bit 7 into carry and the old carry into bit 0. Op 11 shifts right with bit 0 into carry and the old carry into bit 7.
- R8: The four rotates (ops 8 to 11) leave sign, zero, half-carry and parity equal to flags_i.
- R9: The following ops act on the accumulator or the carry alone:
  - op 12 inverts the accumulator and changes no flag;
  - op 13 inverts only the carry;
  - op 14 sets only the carry.
- R10: Op 15 increments and op 16 decrements the accumulator. Both update sign, zero, parity and half-carry, and keep carry.
- R11: Decimal adjust (op 17) works in two steps:
  - It adds 06h when the low nibble exceeds 9 or half-carry is set. Half-carry then shows a carry out of bit 3 from that addition, and is 0 when no addition was made.
  - It then adds 60h when the upper part exceeds 9 (a carry out of bit 7 counts as exceeding) or carry is set. In that case carry becomes 1; otherwise carry is kept.
- R12: For every op that updates them, sign is result bit 7, zero is 1 for a zero result, and parity is 1 when the result holds an even number of one bits.
- R13: Op codes 18 to 31 store acc_i and flags_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; result is stored when high |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte |
| flags_i | input | 5 | Current flags {sign, zero, half-carry, parity, carry} |
| acc_o | output | 8 | Registered new accumulator |
| flags_o | output | 5 | Registered new flags, same layout as flags_i |

## Verification
Every result of this block is due one rising edge after the strobe. There is exactly one register stage between the inputs and acc_o/flags_o, whatever the operation. The bench holds the inputs steady across that edge and updates its behavioural model at the same edge. It then compares both outputs at the following falling edge, before it drives the next inputs. Cycles without a strobe are compared against the held model value, which shows that the outputs keep their values.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

    localparam int DW     = 8;
    localparam int NFLAGS = 5;

    // flag bus positions
    localparam int FL_CY   = 0;
    localparam int FL_PAR  = 1;
    localparam int FL_AC   = 2;
    localparam int FL_ZERO = 3;
    localparam int FL_SIGN = 4;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_RLC = 5'd8,   // rotate kind decoded from op[1:0]
        OP_RRC = 5'd9,
        OP_RAL = 5'd10,
        OP_RAR = 5'd11,
        OP_CPL = 5'd12,
        OP_CMC = 5'd13,
        OP_STC = 5'd14,
        OP_INC = 5'd15,
        OP_DEC = 5'd16,
        OP_DAA = 5'd17
    } alu_op_e;

    // refresh sign, zero and parity from a result byte
    function automatic logic [NFLAGS-1:0] with_szp(input logic [NFLAGS-1:0] f,
                                                   input logic [DW-1:0]     r);
        logic [NFLAGS-1:0] o;
        o          = f;
        o[FL_SIGN] = r[DW-1];
        o[FL_ZERO] = (r == '0);
        o[FL_PAR]  = ~(^r);
        return o;
    endfunction

endpackage

// File: rtl/acu_addsub.sv
module acu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cy_o,
    output logic          hc_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] b_x;
    logic          c_x;
    logic [DW:0]   full_sum;
    logic [HW:0]   half_sum;

    // subtraction as a + ~b + ~borrow; carry sense inverted afterwards
    assign b_x      = sub_i ? ~b_i : b_i;
    assign c_x      = sub_i ? ~cin_i : cin_i;
    assign full_sum = {1'b0, a_i} + {1'b0, b_x} + {{DW{1'b0}}, c_x};
    assign half_sum = {1'b0, a_i[HW-1:0]} + {1'b0, b_x[HW-1:0]} + {{HW{1'b0}}, c_x};

    assign sum_o = full_sum[DW-1:0];
    assign cy_o  = full_sum[DW] ^ sub_i;
    assign hc_o  = half_sum[HW] ^ sub_i;
endmodule

// File: rtl/acu_rotate.sv
module acu_rotate #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic          cy_i,
    input  logic [1:0]    kind_i,   // 0 left, 1 right, 2 left via carry, 3 right via carry
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    always_comb begin
        unique case (kind_i)
            2'd0: begin
                res_o = {a_i[DW-2:0], a_i[DW-1]};
                cy_o  = a_i[DW-1];
            end
            2'd1: begin
                res_o = {a_i[0], a_i[DW-1:1]};
                cy_o  = a_i[0];
            end
            2'd2: begin
                res_o = {a_i[DW-2:0], cy_i};
                cy_o  = a_i[DW-1];
            end
            default: begin
                res_o = {cy_i, a_i[DW-1:1]};
                cy_o  = a_i[0];
            end
        endcase
    end
endmodule

// File: rtl/acu_decadj.sv
module acu_decadj (
    input  logic [7:0] a_i,
    input  logic       cy_i,
    input  logic       ac_i,
    output logic [7:0] res_o,
    output logic       cy_o,
    output logic       ac_o
);
    logic       lo_fix;
    logic       hi_fix;
    logic [4:0] lo_sum;
    logic [8:0] stage1;

    assign lo_fix = (a_i[3:0] > 4'd9) || ac_i;
    assign lo_sum = {1'b0, a_i[3:0]} + (lo_fix ? 5'd6 : 5'd0);
    assign stage1 = {1'b0, a_i} + (lo_fix ? 9'h006 : 9'h000);
    // upper field includes any overflow from the first correction
    assign hi_fix = (stage1[8:4] > 5'd9) || cy_i;

    assign res_o = stage1[7:0] + (hi_fix ? 8'h60 : 8'h00);
    assign cy_o  = hi_fix;
    assign ac_o  = lo_sum[4];
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int NF = NFLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  acc_i,
    input  logic [W-1:0]  opnd_i,
    input  logic [NF-1:0] flags_i,
    output logic [W-1:0]  acc_o,
    output logic [NF-1:0] flags_o
);
    logic          as_sub;
    logic          as_cin;
    logic [W-1:0]  as_b;
    logic [W-1:0]  as_sum;
    logic          as_cy;
    logic          as_hc;
    logic          unit_step;
    logic [W-1:0]  rot_res;
    logic          rot_cy;
    logic [W-1:0]  da_res;
    logic          da_cy;
    logic          da_ac;
    logic [W-1:0]  logic_res;
    logic [W-1:0]  nxt_acc;
    logic [NF-1:0] nxt_fl;

    // operand steering for the shared adder
    always_comb begin
        unit_step = (op_i == OP_INC) || (op_i == OP_DEC);
        as_sub    = (op_i == OP_SUB) || (op_i == OP_SBB) ||
                    (op_i == OP_CMP) || (op_i == OP_DEC);
        as_cin    = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? flags_i[FL_CY] : 1'b0;
        as_b      = unit_step ? {{(W-1){1'b0}}, 1'b1} : opnd_i;
    end

    acu_addsub #(.DW(W)) addsub_i (
        .a_i   (acc_i),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .cy_o  (as_cy),
        .hc_o  (as_hc)
    );

    acu_rotate #(.DW(W)) rotate_i (
        .a_i    (acc_i),
        .cy_i   (flags_i[FL_CY]),
        .kind_i (op_i[1:0]),
        .res_o  (rot_res),
        .cy_o   (rot_cy)
    );

    acu_decadj decadj_i (
        .a_i   (acc_i),
        .cy_i  (flags_i[FL_CY]),
        .ac_i  (flags_i[FL_AC]),
        .res_o (da_res),
        .cy_o  (da_cy),
        .ac_o  (da_ac)
    );

    always_comb begin
        unique case (op_i)
            OP_AND:  logic_res = acc_i & opnd_i;
            OP_OR:   logic_res = acc_i | opnd_i;
            default: logic_res = acc_i ^ opnd_i;
        endcase
    end

    // next-state selection
    always_comb begin
        nxt_acc = acc_i;
        nxt_fl  = flags_i;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                nxt_acc       = as_sum;
                nxt_fl        = with_szp(flags_i, as_sum);
                nxt_fl[FL_CY] = as_cy;
                nxt_fl[FL_AC] = as_hc;
            end
            OP_CMP: begin
                nxt_fl        = with_szp(flags_i, as_sum);
                nxt_fl[FL_CY] = as_cy;
                nxt_fl[FL_AC] = as_hc;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_acc       = logic_res;
                nxt_fl        = with_szp(flags_i, logic_res);
                nxt_fl[FL_CY] = 1'b0;
                nxt_fl[FL_AC] = (op_i == OP_AND);
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                nxt_acc       = rot_res;
                nxt_fl[FL_CY] = rot_cy;
            end
            OP_CPL: nxt_acc = ~acc_i;
            OP_CMC: nxt_fl[FL_CY] = ~flags_i[FL_CY];
            OP_STC: nxt_fl[FL_CY] = 1'b1;
            OP_INC, OP_DEC: begin
                nxt_acc       = as_sum;
                nxt_fl        = with_szp(flags_i, as_sum);
                nxt_fl[FL_AC] = as_hc;
            end
            OP_DAA: begin
                nxt_acc       = da_res;
                nxt_fl        = with_szp(flags_i, da_res);
                nxt_fl[FL_CY] = da_cy;
                nxt_fl[FL_AC] = da_ac;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o   <= '0;
            flags_o <= '0;
        end else if (exec_i) begin
            acc_o   <= nxt_acc;
            flags_o <= nxt_fl;
        end
    end
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk
    import acc_alu8_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                exec_i,
    input logic [4:0]          op_i,
    input logic [DW-1:0]       acc_i,
    input logic [NFLAGS-1:0]   flags_i,
    input logic [DW-1:0]       acc_o,
    input logic [NFLAGS-1:0]   flags_o
);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(acc_o) && $stable(flags_o)));

    // R3
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CMP) |=> (acc_o == $past(acc_i)));

    // R4
    and_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_AND) |=> (flags_o[FL_AC] && !flags_o[FL_CY]));

    // R5
    or_xor_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_OR || op_i == OP_XOR)) |=> (!flags_o[FL_AC] && !flags_o[FL_CY]));

    // R8
    rot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i >= OP_RLC && op_i <= OP_RAR) |=> (flags_o[4:1] == $past(flags_i[4:1])));

    // R9
    cpl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == OP_CPL) |=> (flags_o == $past(flags_i)));

    // R10
    step_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[FL_CY] == $past(flags_i[FL_CY])));

    // R13
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i > OP_DAA) |=> (acc_o == $past(acc_i) && flags_o == $past(flags_i)));
endmodule

bind acc_alu8 acc_alu8_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_i  (exec_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .flags_i (flags_i),
    .acc_o   (acc_o),
    .flags_o (flags_o)
);

// File: tb/acc_alu8_tb_top.sv
`timescale 1ns/1ps
module acc_alu8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [4:0] flags_i = '0;
    logic [7:0] acc_o;
    logic [4:0] flags_o;

    int checks = 0;
    int fails  = 0;
    int exp_acc = 0;
    int exp_fl  = 0;

    always #2.5 clk = ~clk;

    acc_alu8 dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_i  (exec_i),
        .op_i    (op_i),
        .acc_i   (acc_i),
        .opnd_i  (opnd_i),
        .flags_i (flags_i),
        .acc_o   (acc_o),
        .flags_o (flags_o)
    );

    function automatic int setb(int v, int idx, int b);
        return (v & ~(1 << idx)) | ((b & 1) << idx);
    endfunction

    function automatic int with_szp(int f, int r);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        f = setb(f, 4, (r >> 7) & 1);
        f = setb(f, 3, (r == 0) ? 1 : 0);
        f = setb(f, 1, (ones % 2 == 0) ? 1 : 0);
        return f;
    endfunction

    // behavioural reference: returns acc*32 + flags
    function automatic int ref_step(int op, int a, int b, int fl);
        int cy = fl & 1;
        int ac = (fl >> 2) & 1;
        int r  = a;
        int nf = fl;
        int t  = 0;
        int ci = 0;
        case (op)
            0, 1: begin
                ci = (op == 1) ? cy : 0;
                t  = a + b + ci;
                r  = t & 255;
                nf = with_szp(fl, r);
                nf = setb(nf, 0, t > 255);
                nf = setb(nf, 2, ((a & 15) + (b & 15) + ci) > 15);
            end
            2, 3, 4: begin
                ci = (op == 3) ? cy : 0;
                t  = a - b - ci;
                nf = with_szp(fl, t & 255);
                nf = setb(nf, 0, t < 0);
                nf = setb(nf, 2, ((a & 15) - (b & 15) - ci) < 0);
                if (op != 4) r = t & 255;
            end
            5, 6, 7: begin
                r  = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
                nf = with_szp(fl, r);
                nf = setb(nf, 0, 0);
                nf = setb(nf, 2, op == 5);
            end
            8:  begin r = ((a << 1) | (a >> 7)) & 255; nf = setb(fl, 0, a >> 7); end
            9:  begin r = (a >> 1) | ((a & 1) << 7);   nf = setb(fl, 0, a & 1); end
            10: begin r = ((a << 1) | cy) & 255;        nf = setb(fl, 0, a >> 7); end
            11: begin r = (a >> 1) | (cy << 7);         nf = setb(fl, 0, a & 1); end
            12: r = (~a) & 255;
            13: nf = setb(fl, 0, 1 - cy);
            14: nf = setb(fl, 0, 1);
            15: begin
                r  = (a + 1) & 255;
                nf = with_szp(fl, r);
                nf = setb(nf, 2, (a & 15) == 15);
            end
            16: begin
                r  = (a + 255) & 255;
                nf = with_szp(fl, r);
                nf = setb(nf, 2, (a & 15) == 0);
            end
            17: begin
                int nac = 0;
                int ncy = cy;
                t = a;
                if ((a & 15) > 9 || ac == 1) begin
                    nac = ((a & 15) + 6) > 15;
                    t   = t + 6;
                end
                if ((t >> 4) > 9 || cy == 1) begin
                    t   = t + 96;
                    ncy = 1;
                end
                r  = t & 255;
                nf = with_szp(fl, r);
                nf = setb(nf, 0, ncy);
                nf = setb(nf, 2, nac);
            end
            default: ;
        endcase
        return (r << 5) | nf;
    endfunction

    function automatic string req_of(int op);
        if (op <= 3) return "R2";
        if (op == 4) return "R3";
        if (op == 5) return "R4";
        if (op <= 7) return "R5";
        if (op <= 9) return "R6";
        if (op <= 11) return "R7";
        if (op <= 14) return "R9";
        if (op <= 16) return "R10";
        if (op == 17) return "R11";
        return "R13";
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one strobe: drive, update model at the edge, compare after it
    task automatic step(bit ex, int op, int a, int b, int fl);
        int v;
        exec_i  = ex;
        op_i    = op[4:0];
        acc_i   = a[7:0];
        opnd_i  = b[7:0];
        flags_i = fl[4:0];
        @(posedge clk);
        if (ex) begin
            v       = ref_step(op, a, b, fl);
            exp_acc = (v >> 5) & 255;
            exp_fl  = v & 31;
        end
        @(negedge clk);
        check(ex ? req_of(op) : "R1", "acc", int'(acc_o), exp_acc);
        check(ex ? req_of(op) : "R1", "flags", int'(flags_o), exp_fl);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset acc", int'(acc_o), 0);
        check("R1", "reset flags", int'(flags_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 literal examples
        step(1, 8, 8'hA8, 0, 0);
        check("R6", "rlc A8", int'(acc_o), 8'h51);
        check("R6", "rlc cy", int'(flags_o[0]), 1);
        step(1, 9, 8'hA8, 0, 5'h01);
        check("R6", "rrc A8", int'(acc_o), 8'h54);
        check("R6", "rrc cy", int'(flags_o[0]), 0);
        // R8 rotates keep S Z AC P
        step(1, 10, 8'h3C, 0, 5'h1E);
        check("R8", "ral upper flags", int'(flags_o[4:1]), 4'hF);
        step(1, 11, 8'h01, 0, 5'h00);
        check("R7", "rar acc", int'(acc_o), 8'h00);
        check("R8", "rar upper flags", int'(flags_o[4:1]), 4'h0);
        // R3 compare
        step(1, 4, 8'h40, 8'h40, 0);
        check("R3", "cmp equal zero", int'(flags_o[3]), 1);
        check("R3", "cmp acc kept", int'(acc_o), 8'h40);
        step(1, 4, 8'h10, 8'h20, 0);
        check("R3", "cmp less carry", int'(flags_o[0]), 1);
        // R11 decimal adjust
        step(1, 17, 8'h9B, 0, 0);
        check("R11", "daa acc", int'(acc_o), 8'h01);
        check("R11", "daa cy ac", int'({flags_o[2], flags_o[0]}), 2'b11);
        step(1, 17, 8'h15, 0, 5'h04);
        check("R11", "daa ac-only acc", int'(acc_o), 8'h1B);
        // R12 parity
        step(1, 0, 8'h01, 8'h02, 0);
        check("R12", "parity even", int'(flags_o[1]), 1);
        step(1, 0, 8'h03, 8'h04, 0);
        check("R12", "parity odd", int'(flags_o[1]), 0);
        // R10 increment wrap keeps carry
        step(1, 15, 8'hFF, 0, 5'h01);
        check("R10", "inc wrap acc", int'(acc_o), 0);
        check("R10", "inc carry kept", int'(flags_o[0]), 1);
        // R13 unused code then hold (R1)
        step(1, 25, 8'h77, 8'h12, 5'h15);
        check("R13", "unused acc", int'(acc_o), 8'h77);
        step(0, 0, 8'h00, 8'h55, 5'h00);

        // broad sweep
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 31),
                 $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 31));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule